// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast system clock into a stream of single-cycle enable pulses whose long-run rate matches a serial bit rate, even when the clock is not an integer multiple of that rate. It keeps a phase register of `ACC_W` fraction bits plus one carry bit. On each enabled clock a fixed step is added to the fraction bits, and the carry bit that results is the tick. The interval between ticks therefore alternates between the two integers that bracket the ideal division ratio, and the average ratio is exactly `2^ACC_W / STEP`.

The clock frequency, the bit rate and the fraction width are compile-time parameters. The step is derived from them at elaboration. Both operands are pre-scaled by 16 so that every intermediate stays inside 32 bits, and the result is rounded to nearest: `STEP = ((BAUD << (ACC_W-4)) + (CLK_HZ >> 5)) / (CLK_HZ >> 4)`. The build stops if the step comes out zero or larger than half the phase range. A serial transmitter or receiver uses `tick` as its bit-time enable. The `en` input pauses the phase without losing it.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `tick` is low after that edge. After `rst` is released with `en` high, the first tick appears after exactly ceil(2^ACC_W / STEP) enabled clock edges.
- R2: `tick` is never high on two consecutive clock cycles.
- R3: Over any 2^ACC_W consecutive enabled clock edges counted from reset, exactly STEP ticks occur.
- R4: Each interval between successive ticks, counted in enabled edges, equals either floor(2^ACC_W / STEP) or ceil(2^ACC_W / STEP).
- R5: STEP equals the rounded value of BAUD·2^ACC_W/CLK_HZ. For example, it is 59 for a 2 MHz clock, 115200 baud and 10 fraction bits, which gives intervals of 17 and 18 clocks. It is 302 for the default of 25 MHz, 115200 baud and 16 bits.
- R6: When the clock is 1.8432 MHz with 115200 baud and 4 fraction bits, STEP is 1 and every tick interval is exactly 16 clocks.
- R7: A clock edge with `en` low leaves the phase unchanged and leaves `tick` low after that edge. Once the block is enabled again, the tick count over 2^ACC_W enabled edges is still STEP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; clears the phase |
| en | input | 1 | Advance enable; low pauses the phase |
| tick | output | 1 | Single-cycle bit-rate enable pulse |

## Verification
A corrupted phase value or a wrong step shows first as a misplaced first tick after reset. It then appears as an interval that falls outside the two allowed integers, so it is visible within one tick period, which is at most a few hundred clocks. A step that is wrong by only one count can keep every interval legal, but it changes the tick total over a full phase wrap of 2^ACC_W enabled clocks. A pause that loses phase or emits a stray pulse shifts that same total and shows up as a tick directly after a disabled edge.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned CLK_HZ = 25_000_000,
  parameter int unsigned BAUD   = 115_200,
  parameter int unsigned ACC_W  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int unsigned STEP = ((BAUD << (ACC_W - 4)) + (CLK_HZ >> 5)) / (CLK_HZ >> 4);
  localparam int unsigned SPAN = 32'd1 << ACC_W;
  localparam logic [ACC_W:0] STEP_V = (ACC_W+1)'(STEP);

  generate
    if (ACC_W < 4 || ACC_W > 30) begin : g_bad_width
      $error("baud_tick_gen: ACC_W must lie in 4..30");
    end
    if (STEP == 0 || STEP > SPAN / 2) begin : g_bad_step
      $error("baud_tick_gen: step out of range for CLK_HZ/BAUD/ACC_W");
    end
  endgenerate

  logic [ACC_W:0] acc;
  logic [ACC_W:0] frac;

  assign frac = {1'b0, acc[ACC_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= frac + STEP_V;
    else         acc <= frac;
  end

  assign tick = acc[ACC_W];
endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk #(
  parameter int unsigned CLK_HZ = 25_000_000,
  parameter int unsigned BAUD   = 115_200,
  parameter int unsigned ACC_W  = 16
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic tick
);
  localparam int unsigned STEP = ((BAUD << (ACC_W - 4)) + (CLK_HZ >> 5)) / (CLK_HZ >> 4);
  localparam int unsigned SPAN = 32'd1 << ACC_W;
  localparam int unsigned LO   = SPAN / STEP;
  localparam int unsigned HI   = (SPAN + STEP - 1) / STEP;

  int unsigned gap;
  always_ff @(posedge clk) begin
    if (rst) gap <= 0;
    else     gap <= (tick ? 32'd0 : gap) + {31'd0, en};
  end

  AST_RST_QUIET: assert property (@(posedge clk) rst |=> !tick); // R1
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst) tick |=> !tick); // R2
  AST_GAP_RANGE: assert property (@(posedge clk) disable iff (rst) tick |-> (gap == LO || gap == HI)); // R4
  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (rst) !en |=> !tick); // R7
endmodule

bind baud_tick_gen baud_tick_chk #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .tick(tick)
);

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en0 = 1'b1, en1 = 1'b1, en2 = 1'b1;
  logic tk0, tk1, tk2;
  logic [2:0] t;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  baud_tick_gen #(.CLK_HZ(2_000_000), .BAUD(115_200), .ACC_W(10)) u0 (.clk(clk), .rst(rst), .en(en0), .tick(tk0));
  baud_tick_gen #(.CLK_HZ(1_843_200), .BAUD(115_200), .ACC_W(4))  u1 (.clk(clk), .rst(rst), .en(en1), .tick(tk1));
  baud_tick_gen u2 (.clk(clk), .rst(rst), .en(en2), .tick(tk2));

  assign t = {tk2, tk1, tk0};

  function automatic int ideal_step(real fclk, real baud, int n);
    return $rtoi(baud * (2.0 ** n) / fclk + 0.5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int stp[3], pw[3], lo[3], hi[3];
  int first[3], last[3], cnt[3];
  bit prev[3];

  initial begin
    stp[0] = ideal_step(2.0e6, 115200.0, 10);      pw[0] = 1 << 10;
    stp[1] = ideal_step(1.8432e6, 115200.0, 4);    pw[1] = 1 << 4;
    stp[2] = ideal_step(25.0e6, 115200.0, 16);     pw[2] = 1 << 16;
    chk(stp[0] == 59, "R5 step 2MHz", stp[0], 59);
    chk(stp[2] == 302, "R5 step default", stp[2], 302);
    for (int i = 0; i < 3; i++) begin
      lo[i] = pw[i] / stp[i];
      hi[i] = (pw[i] + stp[i] - 1) / stp[i];
      first[i] = 0; last[i] = 0; cnt[i] = 0; prev[i] = 0;
    end

    repeat (3) @(negedge clk);
    chk(t == 3'b000, "R1 quiet in reset", int'(t), 0);
    rst = 1'b0;

    for (int j = 1; j <= 65536; j++) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        if (t[i]) begin
          chk(!prev[i], "R2 no back-to-back tick", 1, 0);
          if (first[i] == 0) first[i] = j;
          else if (i == 1) chk(j - last[i] == 16, "R6 exact 16-clock spacing", j - last[i], 16);
          else chk(j - last[i] == lo[i] || j - last[i] == hi[i], "R4 interval", j - last[i], hi[i]);
          last[i] = j;
          if (j <= pw[i]) cnt[i]++;
        end
        prev[i] = t[i];
      end
    end

    for (int i = 0; i < 3; i++) begin
      chk(first[i] == hi[i], "R1 first tick delay", first[i], hi[i]);
      chk(cnt[i] == stp[i], "R3 ticks per wrap", cnt[i], stp[i]);
    end
    chk(lo[0] == 17 && hi[0] == 18, "R5 interval pair 17/18", lo[0] * 100 + hi[0], 1718);
    chk(cnt[1] == 1, "R6 one tick per 16 clocks", cnt[1], 1);

    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(t == 3'b000, "R1 quiet in second reset", int'(t), 0);
    rst = 1'b0;
    begin
      int ena = 0, nt = 0, k = 0, stray = 0;
      while (ena < 1024) begin
        en0 = (k % 3) != 2;
        @(negedge clk);
        if (en0) ena++;
        else if (tk0) stray++;
        if (tk0) nt++;
        k++;
      end
      chk(stray == 0, "R7 no tick after paused edge", stray, 0);
      chk(nt == stp[0], "R7 ticks per wrap with pauses", nt, stp[0]);
      en0 = 1'b0;
      stray = 0;
      repeat (40) begin
        @(negedge clk);
        if (tk0) stray++;
      end
      chk(stray == 0, "R7 silent during long pause", stray, 0);
      en0 = 1'b1;
      nt = 0;
      for (int j = 1; j <= 1024; j++) begin
        @(negedge clk);
        if (tk0) nt++;
      end
      chk(nt == stp[0], "R7 rate after resume", nt, stp[0]);
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule